// File: doc/BRIEF.md
# Line Reference Loss Monitor with Flywheel

This block watches a horizontal sync pulse stream and decides, line by line, whether the reference is still present. Each pulse is judged against a window centred on the expected line period, with a programmable tolerance. An internal line-timing flywheel produces the block's own H strobe. While the reference is trusted, that strobe follows the input. When the reference is judged lost, the flywheel runs on by itself.

A single missing pulse is tolerated. The flywheel inserts a synthetic H, the lock indication goes high, and tracking continues. A second consecutive miss raises the reference-lost flag and puts the flywheel into freeze. In freeze it repeats the last measured line period from the last H it produced, so no short or double line is emitted on entry. Freeze ends only after two consecutive in-window pulses. On the second of these pulses the flywheel re-phases to the input, so one line may be shortened at that moment. Line-based timing downstream should therefore be treated as unreliable for up to one frame after the reference returns.

The vertical and frame sync inputs are present on the port list but have no influence on any output. All interfaces are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ref_loss_mon`

## Requirements
- R1: The gap of a pulse is the number of clocks since the previous event (accepted pulse, rejected pulse or declared miss); a pulse at the first clock after an event has gap 1. A pulse is accepted when its gap lies within [line_period_i - win_tol_i, line_period_i + win_tol_i], inclusive at both ends. Otherwise it is rejected.
- R2: While not in freeze, an accepted pulse produces h_out_o high during exactly the one clock after the edge that sampled the pulse. The gap of that pulse is stored as the measured line period.
- R3: When the gap reaches line_period_i + win_tol_i with no pulse present, a miss is declared. While not in freeze, the miss produces a synthetic h_out_o strobe with the same one-clock timing. A pulse on that last window clock is accepted and no miss is declared.
- R4: A single miss from the locked state sets lock_lost_o high and leaves ref_lost_o low. The next accepted pulse clears lock_lost_o.
- R5: A second consecutive miss sets both ref_lost_o and lock_lost_o high and enters freeze. ref_lost_o never rises unless lock_lost_o was already high.
- R6: In freeze, h_out_o repeats every stored measured period, counted from the last strobe before freeze. Input pulses, accepted or not, do not move it until relock.
- R7: Freeze ends on the second of two consecutive accepted pulses; a miss or a rejected pulse restarts the count. On that pulse both flags clear and h_out_o strobes in the following clock.
- R8: Outside freeze, a rejected pulse produces no h_out_o strobe and leaves both flags unchanged.
- R9: vsync_i and fsync_i have no effect on any output.
- R10: After reset, lock_lost_o and ref_lost_o are both high and h_out_o is low.
- R11: The tolerance win_tol_i may change between lines and takes effect on the next window. With tolerance 0, a pulse one clock late is preceded by a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hsync_i | input | 1 | Horizontal reference pulse, one clock wide |
| vsync_i | input | 1 | Vertical reference, not monitored |
| fsync_i | input | 1 | Frame reference, not monitored |
| line_period_i | input | CNT_W | Expected line period in clocks |
| win_tol_i | input | CNT_W | Acceptance tolerance in clocks, each side |
| h_out_o | output | 1 | Flywheel H strobe, one clock wide |
| lock_lost_o | output | 1 | High while not fully locked |
| ref_lost_o | output | 1 | High while in freeze |

## Verification
Two functions can fall in the same clock: a pulse arriving on the last clock of the window, and the miss declaration that this clock would otherwise produce. The bench provokes this by delivering a pulse with gap exactly line_period_i + win_tol_i. It then checks that lock_lost_o stays low and that a single h_out_o strobe appears. The bench also provokes the mirror case: with tolerance 0, a pulse one clock after the window end must see the miss already declared and be rejected.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_SLIP = 2'd1,
    ST_FRZ  = 2'd2
  } rlm_state_e;
endpackage

// File: rtl/rlm_window_mon.sv
module rlm_window_mon #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] tol_i,
  output logic             good_o,
  output logic             bad_o,
  output logic             miss_o,
  output logic [CNT_W:0]   gap_o
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] gap_q;
  logic [CW-1:0] win_lo;
  logic [CW-1:0] win_hi;

  always_comb begin
    win_hi = {1'b0, period_i} + {1'b0, tol_i};
    if (tol_i >= period_i) win_lo = CW'(1);
    else                   win_lo = {1'b0, period_i - tol_i};
  end

  assign good_o = hs_i && (gap_q >= win_lo) && (gap_q <= win_hi);
  assign bad_o  = hs_i && !good_o;
  assign miss_o = !hs_i && (gap_q >= win_hi);
  assign gap_o  = gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (hs_i || miss_o)   gap_q <= CW'(1);
    else if (gap_q != '1)      gap_q <= gap_q + CW'(1);
  end
endmodule

// File: rtl/rlm_lock_fsm.sv
module rlm_lock_fsm
  import rlm_pkg::*;
#(
  parameter int RELOCK_CNT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       good_i,
  input  logic       bad_i,
  input  logic       miss_i,
  output rlm_state_e state_o,
  output logic       relock_o
);
  localparam int GW = $clog2(RELOCK_CNT + 1);

  rlm_state_e    state_q;
  logic [GW-1:0] run_q;

  assign state_o  = state_q;
  assign relock_o = (state_q == ST_FRZ) && good_i && (run_q == GW'(RELOCK_CNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FRZ;
      run_q   <= '0;
    end else begin
      case (state_q)
        ST_LOCK: if (miss_i) state_q <= ST_SLIP;
        ST_SLIP: begin
          if (good_i)      state_q <= ST_LOCK;
          else if (miss_i) state_q <= ST_FRZ;
        end
        default: begin
          if (relock_o) begin
            state_q <= ST_LOCK;
            run_q   <= '0;
          end else if (good_i) begin
            run_q <= run_q + GW'(1);
          end else if (bad_i || miss_i) begin
            run_q <= '0;
          end
        end
      endcase
    end
  end

  // R4: a miss while locked moves to the slip state
  assert_slip_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && miss_i) |=> (state_q == ST_SLIP));

  // R4: an accepted pulse while slipping restores lock
  assert_slip_recovers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLIP && good_i) |=> (state_q == ST_LOCK));

  // R5: a second consecutive miss enters freeze
  assert_second_miss_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLIP && miss_i) |=> (state_q == ST_FRZ));

  // R7: freeze is left only on an accepted pulse
  assert_exit_on_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FRZ && $past(state_q == ST_FRZ)) |-> $past(good_i));
endmodule

// File: rtl/rlm_flywheel.sv
module rlm_flywheel
  import rlm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rlm_state_e       state_i,
  input  logic             good_i,
  input  logic             miss_i,
  input  logic             relock_i,
  input  logic [CNT_W:0]   gap_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             h_o
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] fw_q;
  logic [CW-1:0] per_q;
  logic          per_vld_q;
  logic [CW-1:0] per_eff;
  logic          genlock, wrap, evt, load;
  logic          h_q;

  assign per_eff = per_vld_q ? per_q : {1'b0, period_i};
  assign genlock = (state_i != ST_FRZ);
  assign wrap    = !genlock && (fw_q >= per_eff);
  assign load    = good_i && (genlock || relock_i);
  assign evt     = (genlock && (good_i || miss_i)) || wrap || relock_i;
  assign h_o     = h_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_q      <= '0;
      per_q     <= '0;
      per_vld_q <= 1'b0;
      h_q       <= 1'b0;
    end else begin
      h_q <= evt;
      if (evt)               fw_q <= CW'(1);
      else if (fw_q != '1)   fw_q <= fw_q + CW'(1);
      if (load) begin
        per_q     <= gap_i;
        per_vld_q <= 1'b1;
      end
    end
  end

  // R6: the free-running strobe never repeats on consecutive clocks in freeze
  assert_freeze_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_FRZ && h_q && !relock_i && per_eff > CW'(1)) |=> !h_q);
endmodule

// File: rtl/ref_loss_mon.sv
module ref_loss_mon
  import rlm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RELOCK_CNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             fsync_i,
  input  logic [CNT_W-1:0] line_period_i,
  input  logic [CNT_W-1:0] win_tol_i,
  output logic             h_out_o,
  output logic             lock_lost_o,
  output logic             ref_lost_o
);
  logic           good, bad, miss, relock;
  logic [CNT_W:0] gap;
  rlm_state_e     state;
  logic           vert_unused;

  // vertical and frame references are deliberately not monitored
  assign vert_unused = vsync_i ^ fsync_i;

  rlm_window_mon #(.CNT_W(CNT_W)) mon_i (
    .clk(clk), .rst_n(rst_n), .hs_i(hsync_i),
    .period_i(line_period_i), .tol_i(win_tol_i),
    .good_o(good), .bad_o(bad), .miss_o(miss), .gap_o(gap)
  );

  rlm_lock_fsm #(.RELOCK_CNT(RELOCK_CNT)) fsm_i (
    .clk(clk), .rst_n(rst_n), .good_i(good), .bad_i(bad), .miss_i(miss),
    .state_o(state), .relock_o(relock)
  );

  rlm_flywheel #(.CNT_W(CNT_W)) fw_i (
    .clk(clk), .rst_n(rst_n), .state_i(state), .good_i(good), .miss_i(miss),
    .relock_i(relock), .gap_i(gap), .period_i(line_period_i), .h_o(h_out_o)
  );

  assign lock_lost_o = (state != ST_LOCK);
  assign ref_lost_o  = (state == ST_FRZ);

  // R5: freeze is only reached after lock was already lost
  assert_freeze_after_slip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_lost_o) |-> $past(lock_lost_o));
endmodule

// File: tb/ref_loss_mon_tb_top.sv
module ref_loss_mon_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hsync = 1'b0;
  logic             vsync = 1'b0;
  logic             fsync = 1'b0;
  logic [CNT_W-1:0] period = 16'd20;
  logic [CNT_W-1:0] tol = 16'd2;
  logic             h_out, lock_lost, ref_lost;
  logic             wiggle = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ref_loss_mon #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync), .fsync_i(fsync),
    .line_period_i(period), .win_tol_i(tol),
    .h_out_o(h_out), .lock_lost_o(lock_lost), .ref_lost_o(ref_lost)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: drive pulse at a falling edge, return at the next falling edge
  task automatic step(input logic hs);
    hsync = hs;
    if (wiggle) begin
      vsync = ~vsync;
      fsync = (vsync == fsync);
    end
    @(negedge clk);
    hsync = 1'b0;
  endtask

  // gap-1 quiet clocks then an in-window pulse while locked
  task automatic line(input int gap, input string req);
    for (int i = 1; i < gap; i++) begin
      step(1'b0);
      chk(req, "h_out between pulses", h_out, 0);
      chk(req, "lock_lost between pulses", lock_lost, 0);
    end
    step(1'b1);
    chk(req, "h_out after pulse", h_out, 1);
    chk(req, "lock_lost after pulse", lock_lost, 0);
    chk(req, "ref_lost after pulse", ref_lost, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10", "lock_lost at reset", lock_lost, 1);
    chk("R10", "ref_lost at reset", ref_lost, 1);
    chk("R10", "h_out at reset", h_out, 0);
  endtask

  task automatic t_acquire;
    step(1'b1);  // gap tiny: rejected
    chk("R7", "ref_lost after rejected pulse", ref_lost, 1);
    repeat (19) step(1'b0);
    step(1'b1);  // first accepted
    chk("R7", "ref_lost after one good", ref_lost, 1);
    chk("R7", "lock_lost after one good", lock_lost, 1);
    repeat (19) step(1'b0);
    step(1'b1);  // second accepted: relock
    chk("R7", "ref_lost after two good", ref_lost, 0);
    chk("R7", "lock_lost after two good", lock_lost, 0);
    chk("R7", "h_out on relock", h_out, 1);
  endtask

  task automatic t_track;
    line(20, "R2");
    line(19, "R2");
    line(21, "R1");
    line(20, "R2");
  endtask

  task automatic t_vert_ignored;
    wiggle = 1'b1;
    line(20, "R9");
    line(20, "R9");
    line(20, "R9");
    wiggle = 1'b0;
  endtask

  task automatic t_window_edges;
    line(22, "R3");  // pulse on the last window clock: accepted, no miss
    line(18, "R1");  // lower edge
    for (int i = 1; i < 17; i++) step(1'b0);
    step(1'b1);      // gap 17: rejected
    chk("R8", "h_out after rejected pulse", h_out, 0);
    chk("R8", "lock_lost after rejected pulse", lock_lost, 0);
    chk("R8", "ref_lost after rejected pulse", ref_lost, 0);
    line(20, "R1");
  endtask

  task automatic t_tolerance;
    tol = 16'd0;
    line(20, "R11");
    for (int i = 1; i < 20; i++) step(1'b0);
    step(1'b0);      // gap 20 reached without pulse: miss
    chk("R11", "lock_lost at zero-tol miss", lock_lost, 1);
    chk("R3", "synthetic h_out", h_out, 1);
    step(1'b1);      // one clock late: rejected
    chk("R11", "late pulse rejected h_out", h_out, 0);
    chk("R11", "lock_lost stays", lock_lost, 1);
    for (int i = 1; i < 20; i++) step(1'b0);
    step(1'b1);
    chk("R4", "lock_lost cleared by good pulse", lock_lost, 0);
    tol = 16'd2;
    line(20, "R11");
  endtask

  task automatic t_single_miss;
    for (int i = 1; i <= 21; i++) begin
      step(1'b0);
      chk("R3", "no miss before window end", lock_lost, 0);
    end
    step(1'b0);
    chk("R4", "lock_lost after one miss", lock_lost, 1);
    chk("R4", "ref_lost after one miss", ref_lost, 0);
    chk("R3", "synthetic h_out at window end", h_out, 1);
    for (int i = 1; i < 21; i++) step(1'b0);
    step(1'b1);      // gap 21: accepted, stored as period
    chk("R4", "lock_lost cleared", lock_lost, 0);
    chk("R2", "h_out on good after miss", h_out, 1);
  endtask

  task automatic t_freeze;
    logic exp_h;
    for (int i = 1; i <= 22; i++) step(1'b0);
    chk("R4", "slip after first miss", lock_lost, 1);
    for (int i = 1; i <= 21; i++) step(1'b0);
    chk("R4", "still not frozen", ref_lost, 0);
    step(1'b0);
    chk("R5", "ref_lost on second miss", ref_lost, 1);
    chk("R5", "lock_lost on second miss", lock_lost, 1);
    chk("R5", "h_out on entry strobe", h_out, 1);
    wiggle = 1'b1;
    for (int i = 1; i <= 45; i++) begin
      step(i == 5 || i == 25 || i == 45);
      exp_h = (i == 21 || i == 42 || i == 45);
      chk((i == 45) ? "R7" : "R6", "h_out in freeze", h_out, exp_h);
      chk("R7", "ref_lost during relock", ref_lost, (i < 45));
      chk("R7", "lock_lost during relock", lock_lost, (i < 45));
    end
    wiggle = 1'b0;
    line(20, "R7");
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_track();
    t_vert_ignored();
    t_window_edges();
    t_tolerance();
    t_single_miss();
    t_freeze();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule